// File: doc/BRIEF.md
# Multi-Policy Register Bank

This block is a bank of 32-bit registers reached over a simple request/response bus. A requester presents a 12-bit word address, a read-or-write opcode, a 4-bit byte mask, a size code and write data on a valid/ready request channel. The bank answers every request with exactly one response that carries read data on a valid/ready response channel. The bank holds one request at a time. While a response is waiting, `req_ready` is low and no new request is taken. A response that is not taken stays on the channel, unchanged, until `rsp_ready` is seen high.

Each register is built from field cells that have a fixed access policy: read-write, read-only, write-1-to-clear, write-1-to-set, clear-on-read or write-only. Fields that have a hardware path take a load strobe and a load value from surrounding logic (`*_de`, `*_d`). Every field drives its current value out on a `*_q` port. One word packs eight 4-bit fields, each with its own policy. A second register is held outside the bank. Reads of it return the value that outside logic supplies, and a software write to it appears as a one-cycle strobe together with the write data.

Top module: `regbank_top`

## Requirements
- R1: `req_ready` equals the inverse of `rsp_valid`. A request is accepted on an edge where `req_valid` and `req_ready` are both high. `rsp_valid` rises on that edge and stays high, with `rsp_rdata` unchanged, until an edge where `rsp_ready` is high. Every accepted request gets one response. Read data is the register content before the request's own effect takes place.
- R2: The word at 0x000 is a plain read-write register. Its reset value is 0xA5C30F1E. A write replaces it, and `plain_q` and reads return the stored value.
- R3: The word at 0x004 implements only the bits in mask 0x0000FF13. Its reset value is 0x00009A03. Writes store `wdata & 0x0000FF13`, and unimplemented bits read as 0 and drive 0 on `part_q`.
- R4: The word at 0x008 is read-write with a hardware load. `hwrw_de` loads `hwrw_d`, and a software write accepted on the same edge wins. Its reset value is 0x0C000C00.
- R5: The mixed word at 0x200 has a reset value of 0x9E7B5C3D. Bits [3:0] and [7:4] are read-write. Bits [11:8] and [15:12] are read-only. Only nibble indices 1, 3, 4, 5 and 6 (bit groups [7:4], [15:12], [19:16], [23:20], [27:24]) honour `mix_de[i]`/`mix_d[4i+3:4i]`. Nibbles 0, 2 and 7 ignore `mix_de`, so bits [11:8] never change after reset.
- R6: In the mixed word, a write clears the bits of [19:16] where the write data is 1, and sets the bits of [23:20] where the write data is 1. When a hardware load and a write hit one of these fields on the same edge, the clear or set applies to the loaded value. For the read-write nibble [7:4], the software write wins over a same-edge load.
- R7: Bits [27:24] of the mixed word clear to 0 after an accepted read of 0x200, and the read returns the value they held before. Writes have no effect on these bits. A read clears them even when a hardware load arrives on the same edge.
- R8: Bits [31:28] of the mixed word are write-only. Writes store the data, which appears on `mix_q[31:28]`, and reads return 0 in these bits.
- R9: The word at 0x204 is held outside the bank. A read returns `ext_rdata` as it is on the accept edge. A full write to 0x204 drives `ext_qe` high during the accept cycle, with `ext_q` equal to `req_wdata`. No other request raises `ext_qe`.
- R10: The word at 0x208 is constant. It always reads 0x5A693C0F and ignores writes.
- R11: A write takes effect only when `req_mask` is 4'hF and `req_size` is 2 (four bytes). Other writes change nothing but still get a response. Reads of unmapped addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address of the word |
| req_mask | input | 4 | Byte mask; a write needs all ones |
| req_size | input | 2 | log2 of the byte count; a write needs 2 |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 32 | Read data (0 for writes to non-readable words) |
| plain_q | output | 32 | Value of word 0x000 |
| part_q | output | 32 | Value of word 0x004 |
| hwrw_q | output | 32 | Value of word 0x008 |
| hwrw_de | input | 1 | Load strobe for word 0x008 |
| hwrw_d | input | 32 | Load value for word 0x008 |
| mix_q | output | 32 | Value of the mixed word 0x200 |
| mix_de | input | 8 | Per-nibble load strobes for the mixed word |
| mix_d | input | 32 | Per-nibble load values for the mixed word |
| ext_q | output | 32 | Write data presented to the outside register |
| ext_qe | output | 1 | Write strobe for the outside register |
| ext_rdata | input | 32 | Read value supplied by the outside register |

## Verification
The hardest situation to reach from the ports is a hardware load that lands on the exact edge where a bus request is accepted. Examples are a load into the write-1-to-clear field during a write, or a load into the clear-on-read field during a read. Acceptance depends on `rsp_valid`, so the stimulus first waits until the bank is idle at a falling edge. It then raises the load strobe together with `req_valid`, so both meet at the next rising edge. A behavioural model in the bench follows each edge, including a stalling `rsp_ready` pattern, and every output is compared with it on every cycle.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [2:0] {
    POL_RW,
    POL_RO,
    POL_W1C,
    POL_W1S,
    POL_RC,
    POL_WO
  } policy_e;

  // Policy of each nibble of the mixed word, by nibble index.
  function automatic policy_e mix_policy(input int idx);
    case (idx)
      0, 1:    return POL_RW;
      2, 3:    return POL_RO;
      4:       return POL_W1C;
      5:       return POL_W1S;
      6:       return POL_RC;
      default: return POL_WO;
    endcase
  endfunction

endpackage

// File: rtl/regbank_field.sv
module regbank_field
  import regbank_pkg::*;
#(
  parameter int          W       = 4,
  parameter policy_e     POLICY  = POL_RW,
  parameter logic [W-1:0] RESET  = '0,
  parameter bit          HW_PATH = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_we,
  input  logic         sw_re,
  input  logic [W-1:0] sw_wd,
  input  logic         hw_de,
  input  logic [W-1:0] hw_d,
  output logic [W-1:0] q
);

  logic         de_eff;
  logic [W-1:0] base;
  logic [W-1:0] nxt;
  logic [W-1:0] q_r;

  assign de_eff = HW_PATH && hw_de;
  assign base   = de_eff ? hw_d : q_r;

  always_comb begin
    nxt = base;
    case (POLICY)
      POL_RW, POL_WO: if (sw_we) nxt = sw_wd;
      POL_W1C:        if (sw_we) nxt = base & ~sw_wd;
      POL_W1S:        if (sw_we) nxt = base | sw_wd;
      POL_RC:         if (sw_re) nxt = '0;
      default:        nxt = base;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= RESET;
    else        q_r <= nxt;
  end

  assign q = q_r;

  logic unused_inputs;
  assign unused_inputs = ^{sw_we, sw_re, sw_wd, hw_de, hw_d};

  if (POLICY == POL_RC) begin : g_rc_chk
    // R7
    rc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_re |=> (q_r == '0));
  end
  if (POLICY == POL_W1C) begin : g_w1c_chk
    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we && !de_eff) |=> ((q_r & $past(sw_wd)) == '0));
  end
  if (POLICY == POL_W1S) begin : g_w1s_chk
    // R6
    w1s_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_we |=> ((q_r & $past(sw_wd)) == $past(sw_wd)));
  end

endmodule

// File: rtl/regbank_bus.sv
module regbank_bus #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  output logic          accept,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] rsp_rdata
);

  assign req_ready = !rsp_valid;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R1
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R1
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> !rsp_valid);

endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int              DW        = 32,
  parameter int              AW        = 12,
  parameter logic [AW-1:0]   A_PLAIN   = 12'h000,
  parameter logic [AW-1:0]   A_PART    = 12'h004,
  parameter logic [AW-1:0]   A_HWRW    = 12'h008,
  parameter logic [AW-1:0]   A_MIX     = 12'h200,
  parameter logic [AW-1:0]   A_EXT     = 12'h204,
  parameter logic [AW-1:0]   A_CONST   = 12'h208,
  parameter logic [DW-1:0]   RST_PLAIN = 32'hA5C30F1E,
  parameter logic [DW-1:0]   PART_MASK = 32'h0000FF13,
  parameter logic [DW-1:0]   RST_PART  = 32'h00009A03,
  parameter logic [DW-1:0]   RST_HWRW  = 32'h0C000C00,
  parameter logic [DW-1:0]   RST_MIX   = 32'h9E7B5C3D,
  parameter logic [DW-1:0]   CONST_VAL = 32'h5A693C0F,
  parameter int              NIB       = 4,
  parameter logic [DW/NIB-1:0] MIX_HW  = 8'b0111_1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW/8-1:0]   req_mask,
  input  logic [1:0]        req_size,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_rdata,
  output logic [DW-1:0]     plain_q,
  output logic [DW-1:0]     part_q,
  output logic [DW-1:0]     hwrw_q,
  input  logic              hwrw_de,
  input  logic [DW-1:0]     hwrw_d,
  output logic [DW-1:0]     mix_q,
  input  logic [DW/NIB-1:0] mix_de,
  input  logic [DW-1:0]     mix_d,
  output logic [DW-1:0]     ext_q,
  output logic              ext_qe,
  input  logic [DW-1:0]     ext_rdata
);

  localparam int NF        = DW / NIB;
  localparam int FULL_SIZE = $clog2(DW / 8);

  function automatic logic [DW-1:0] mix_read_mask();
    logic [DW-1:0] m;
    m = '1;
    for (int i = 0; i < NF; i++)
      if (mix_policy(i) == POL_WO) m[i*NIB +: NIB] = '0;
    return m;
  endfunction

  localparam logic [DW-1:0] MIX_RD_MASK = mix_read_mask();

  logic          accept;
  logic [DW-1:0] rd_mux;
  logic          full_wr;
  logic          sw_rd;
  logic          we_plain, we_part, we_hwrw, we_mix;
  logic          re_mix, re_const;
  logic [DW-1:0] const_q;

  regbank_bus #(.DW(DW)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .accept    (accept),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rd_data   (rd_mux),
    .rsp_rdata (rsp_rdata)
  );

  assign full_wr  = accept && req_write && (req_mask == '1) &&
                    (req_size == 2'(FULL_SIZE));
  assign sw_rd    = accept && !req_write;
  assign we_plain = full_wr && (req_addr == A_PLAIN);
  assign we_part  = full_wr && (req_addr == A_PART);
  assign we_hwrw  = full_wr && (req_addr == A_HWRW);
  assign we_mix   = full_wr && (req_addr == A_MIX);
  assign re_mix   = sw_rd && (req_addr == A_MIX);
  assign re_const = sw_rd && (req_addr == A_CONST);

  assign ext_qe = full_wr && (req_addr == A_EXT);
  assign ext_q  = req_wdata;

  regbank_field #(.W(DW), .POLICY(POL_RW), .RESET(RST_PLAIN), .HW_PATH(1'b0)) u_plain (
    .clk(clk), .rst_n(rst_n), .sw_we(we_plain), .sw_re(1'b0), .sw_wd(req_wdata),
    .hw_de(1'b0), .hw_d('0), .q(plain_q)
  );

  regbank_field #(.W(DW), .POLICY(POL_RW), .RESET(RST_PART & PART_MASK), .HW_PATH(1'b0)) u_part (
    .clk(clk), .rst_n(rst_n), .sw_we(we_part), .sw_re(1'b0), .sw_wd(req_wdata & PART_MASK),
    .hw_de(1'b0), .hw_d('0), .q(part_q)
  );

  regbank_field #(.W(DW), .POLICY(POL_RW), .RESET(RST_HWRW), .HW_PATH(1'b1)) u_hwrw (
    .clk(clk), .rst_n(rst_n), .sw_we(we_hwrw), .sw_re(1'b0), .sw_wd(req_wdata),
    .hw_de(hwrw_de), .hw_d(hwrw_d), .q(hwrw_q)
  );

  for (genvar gi = 0; gi < NF; gi++) begin : g_mix
    regbank_field #(
      .W       (NIB),
      .POLICY  (mix_policy(gi)),
      .RESET   (RST_MIX[gi*NIB +: NIB]),
      .HW_PATH (MIX_HW[gi])
    ) u_nib (
      .clk   (clk),
      .rst_n (rst_n),
      .sw_we (we_mix),
      .sw_re (re_mix),
      .sw_wd (req_wdata[gi*NIB +: NIB]),
      .hw_de (mix_de[gi]),
      .hw_d  (mix_d[gi*NIB +: NIB]),
      .q     (mix_q[gi*NIB +: NIB])
    );
  end

  regbank_field #(.W(DW), .POLICY(POL_RO), .RESET(CONST_VAL), .HW_PATH(1'b0)) u_const (
    .clk(clk), .rst_n(rst_n), .sw_we(1'b0), .sw_re(1'b0), .sw_wd('0),
    .hw_de(1'b0), .hw_d('0), .q(const_q)
  );

  always_comb begin
    case (req_addr)
      A_PLAIN: rd_mux = plain_q;
      A_PART:  rd_mux = part_q;
      A_HWRW:  rd_mux = hwrw_q;
      A_MIX:   rd_mux = mix_q & MIX_RD_MASK;
      A_EXT:   rd_mux = ext_rdata;
      A_CONST: rd_mux = const_q;
      default: rd_mux = '0;
    endcase
  end

  // R10
  const_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    re_const |=> (rsp_valid && rsp_rdata == CONST_VAL));

endmodule

// File: tb/tb_regbank_top.sv
module tb_regbank_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_mask = 4'hF;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic        hwrw_de = 1'b0;
  logic [31:0] hwrw_d = '0;
  logic [7:0]  mix_de = '0;
  logic [31:0] mix_d = '0;
  logic [31:0] ext_rdata = '0;
  logic        req_ready, rsp_valid, ext_qe;
  logic [31:0] rsp_rdata, plain_q, part_q, hwrw_q, mix_q, ext_q;

  always #10 clk = ~clk;

  regbank_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_mask(req_mask),
    .req_size(req_size), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .plain_q(plain_q),
    .part_q(part_q), .hwrw_q(hwrw_q), .hwrw_de(hwrw_de), .hwrw_d(hwrw_d),
    .mix_q(mix_q), .mix_de(mix_de), .mix_d(mix_d), .ext_q(ext_q),
    .ext_qe(ext_qe), .ext_rdata(ext_rdata)
  );

  int checks = 0;
  int fails = 0;
  int cnum = 0;
  int bp = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_plain, m_part, m_hwrw, m_mix, m_rd;
  bit          m_rv;

  function automatic logic [31:0] mread(input logic [11:0] a);
    case (a)
      12'h000: return m_plain;
      12'h004: return m_part;
      12'h008: return m_hwrw;
      12'h200: return {4'h0, m_mix[27:0]};
      12'h204: return ext_rdata;
      12'h208: return 32'h5A693C0F;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit          acc, wr, rd;
    logic [3:0]  nb, wd;
    logic [7:0]  hwp;
    logic [31:0] nm;
    if (!rst_n) begin
      m_plain = 32'hA5C30F1E; m_part = 32'h00009A03; m_hwrw = 32'h0C000C00;
      m_mix = 32'h9E7B5C3D; m_rd = 32'h0; m_rv = 1'b0;
    end else begin
      hwp = 8'h7A;
      acc = req_valid && !m_rv;
      wr  = acc && req_write && req_mask == 4'hF && req_size == 2'd2;
      rd  = acc && !req_write;
      if (acc) m_rd = mread(req_addr);
      if (hwrw_de) m_hwrw = hwrw_d;
      if (wr && req_addr == 12'h008) m_hwrw = req_wdata;
      if (wr && req_addr == 12'h000) m_plain = req_wdata;
      if (wr && req_addr == 12'h004) m_part = req_wdata & 32'h0000FF13;
      for (int i = 0; i < 8; i++) begin
        nb = m_mix[i*4 +: 4];
        wd = req_wdata[i*4 +: 4];
        if (hwp[i] && mix_de[i]) nb = mix_d[i*4 +: 4];
        if (wr && req_addr == 12'h200) begin
          case (i)
            0, 1, 7: nb = wd;
            4:       nb = nb & ~wd;
            5:       nb = nb | wd;
            default: ;
          endcase
        end
        if (rd && req_addr == 12'h200 && i == 6) nb = 4'h0;
        nm[i*4 +: 4] = nb;
      end
      m_mix = nm;
      if (acc) m_rv = 1'b1;
      else if (rsp_ready) m_rv = 1'b0;
    end
  end

  task automatic cyc();
    bit eqe;
    @(negedge clk);
    cnum++;
    if (rst_n) begin
      chk("R1 req_ready", {31'b0, req_ready}, {31'b0, !m_rv});
      chk("R1 rsp_valid", {31'b0, rsp_valid}, {31'b0, m_rv});
      if (m_rv) chk("R1 rsp_rdata", rsp_rdata, m_rd);
      chk("R2 plain_q", plain_q, m_plain);
      chk("R3 part_q", part_q, m_part);
      chk("R4 hwrw_q", hwrw_q, m_hwrw);
      chk("R5 mix_q", mix_q, m_mix);
      eqe = req_valid && !m_rv && req_write && req_mask == 4'hF &&
            req_size == 2'd2 && req_addr == 12'h204;
      chk("R9 ext_qe", {31'b0, ext_qe}, {31'b0, eqe});
      if (eqe) chk("R9 ext_q", ext_q, req_wdata);
    end
    rsp_ready = (bp == 0) ? 1'b1 : (bp == 1) ? ((cnum % 3) != 1) : 1'b0;
  endtask

  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                      input logic [3:0] m, input logic [1:0] s, output logic [31:0] rdat);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    req_mask = m; req_size = s;
    while (!req_ready) cyc();
    cyc();
    req_valid = 1'b0;
    rdat = rsp_rdata;
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    xfer(1'b1, a, d, 4'hF, 2'd2, dummy);
  endtask

  task automatic rd32(input logic [11:0] a, output logic [31:0] d);
    xfer(1'b0, a, 32'h0, 4'hF, 2'd2, d);
  endtask

  task automatic wait_idle();
    while (!req_ready) cyc();
  endtask

  initial begin : main
    logic [31:0] v;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk("R1 reset req_ready", {31'b0, req_ready}, 32'h1);
    chk("R1 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk("R2 reset plain_q", plain_q, 32'hA5C30F1E);
    rd32(12'h000, v); chk("R2 read after reset", v, 32'hA5C30F1E);
    wr32(12'h000, 32'hDEADBEEF);
    rd32(12'h000, v); chk("R2 read after write", v, 32'hDEADBEEF);

    bp = 1;
    wr32(12'h004, 32'hFFFFFFFF);
    rd32(12'h004, v); chk("R3 implemented bits only", v, 32'h0000FF13);
    wr32(12'h004, 32'h0);
    rd32(12'h004, v); chk("R3 cleared", v, 32'h0);

    wait_idle();
    hwrw_d = 32'h13572468; hwrw_de = 1'b1; cyc(); hwrw_de = 1'b0;
    rd32(12'h008, v); chk("R4 hardware load", v, 32'h13572468);
    wait_idle();
    hwrw_de = 1'b1; hwrw_d = 32'h0F0F0F0F;
    wr32(12'h008, 32'hAAAA5555);
    hwrw_de = 1'b0;
    rd32(12'h008, v); chk("R4 write wins over load", v, 32'hAAAA5555);

    rd32(12'h200, v); chk("R8 mixed reset read", v, 32'h0E7B5C3D);
    chk("R7 clear after read", mix_q, 32'h907B5C3D);
    rd32(12'h200, v); chk("R7 second read", v, 32'h007B5C3D);
    wr32(12'h200, 32'hFFFFFFFF);
    chk("R6 mixed after all-ones write", mix_q, 32'hF0F05CFF);
    rd32(12'h200, v); chk("R8 write-only reads zero", v, 32'h00F05CFF);

    xfer(1'b1, 12'h200, 32'h0, 4'h3, 2'd2, v);
    chk("R11 partial mask ignored", mix_q, 32'hF0F05CFF);
    chk("R11 response for ignored write", {31'b0, rsp_valid}, 32'h1);
    xfer(1'b1, 12'h000, 32'h0, 4'hF, 2'd1, v);
    chk("R11 short size ignored", plain_q, 32'hDEADBEEF);

    wait_idle();
    mix_d = 32'h12345678; mix_de = 8'hFF; cyc(); mix_de = 8'h0;
    chk("R5 per-nibble hardware load", mix_q, 32'hF2345C7F);

    wait_idle();
    mix_de = 8'hFF; mix_d = 32'hFFFFFFFF;
    wr32(12'h200, 32'h11111111);
    mix_de = 8'h0;
    chk("R6 clear/set on loaded value", mix_q, 32'h1FFEFC11);

    wait_idle();
    mix_de = 8'h40; mix_d = 32'h0A000000;
    rd32(12'h200, v);
    mix_de = 8'h0;
    chk("R7 read returns pre-clear value", v, 32'h0FFEFC11);
    chk("R7 read beats same-edge load", mix_q, 32'h10FEFC11);

    ext_rdata = 32'h31415926;
    rd32(12'h204, v); chk("R9 outside read", v, 32'h31415926);
    wait_idle();
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h204;
    req_wdata = 32'hCAFEF00D; req_mask = 4'hF; req_size = 2'd2;
    #1;
    chk("R9 strobe in accept cycle", {31'b0, ext_qe}, 32'h1);
    chk("R9 strobe data", ext_q, 32'hCAFEF00D);
    cyc();
    req_valid = 1'b0;
    #1;
    chk("R9 strobe ends", {31'b0, ext_qe}, 32'h0);

    rd32(12'h208, v); chk("R10 constant", v, 32'h5A693C0F);
    wr32(12'h208, 32'h0);
    rd32(12'h208, v); chk("R10 write ignored", v, 32'h5A693C0F);

    wr32(12'h100, 32'hFFFFFFFF);
    rd32(12'h100, v); chk("R11 unmapped reads zero", v, 32'h0);

    wait_idle();
    bp = 2; rsp_ready = 1'b0;
    rd32(12'h000, v);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h004;
    repeat (4) cyc();
    chk("R1 stalled ready low", {31'b0, req_ready}, 32'h0);
    chk("R1 stalled response held", {31'b0, rsp_valid}, 32'h1);
    chk("R1 stalled data held", rsp_rdata, 32'hDEADBEEF);
    bp = 0;
    rd32(12'h004, v); chk("R1 queued request served", v, 32'h0);

    repeat (3) cyc();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R1 actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule